// File: doc/BRIEF.md
# Controlled/Uncontrolled Port Arbiter

This block merges two packet sources onto a single 512-bit transmit lane. The word is cut into four 128-bit segments. Each segment carries a two-bit marker that says whether it opens a packet, carries payload, closes a packet, or is empty.

The first source is the controlled path. It comes from an upstream deframer that may alternate words of different streams from one cycle to the next. Each of its words carries a stream number. The second source is the uncontrolled path. The user drives it directly, one whole packet at a time.

The controlled path always has priority. The uncontrolled path is admitted only when the controlled path is idle and no controlled packet on the uncontrolled packet's stream is still open. Once an uncontrolled packet has started, it keeps the lane until its closing word has been taken. The merged word leaves through one register stage with a valid/ready handshake.

Top module: `cup_port_arbiter`

## Requirements
- R1: While reset is held, `out_valid` is low. Reset also clears every stream's open-packet state, so an uncontrolled packet on any stream can be admitted right after reset.
- R2: A controlled word accepted on a clock edge (`ctl_valid` and `ctl_ready` high) appears on the output after that edge with the same stream number, data and markers.
- R3: When `ctl_valid` is high and no uncontrolled packet is in progress, `unc_ready` is low.
- R4: Take a stream on which a controlled word with a start marker (code 2) has been accepted, and on which no later closing marker (code 3) has been accepted. While that holds, an uncontrolled packet on the same stream is not admitted, even when the controlled path is idle.
- R5: Markers within a word are read from segment 0 (bits 1:0) up to segment 3 (bits 7:6). If a controlled word closes a packet and then opens another packet in a higher segment, its stream stays open and the uncontrolled path stays blocked on that stream.
- R6: If a controlled word opens and closes a packet within itself, its stream is closed afterwards. An uncontrolled packet on that stream is then admitted in the next cycle in which the controlled path is idle.
- R7: A controlled packet that is open on one stream does not block an uncontrolled packet on a different stream while the controlled path is idle.
- R8: Once an uncontrolled word with a start marker and no closing marker has been accepted, `ctl_ready` stays low. `unc_ready` stays high while the output can advance. Both hold until an uncontrolled word with a closing marker is accepted, so output packets never interleave.
- R9: While `out_valid` is high and `out_ready` is low, the output word is held unchanged, and both `ctl_ready` and `unc_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_valid | input | 1 | Controlled word valid |
| ctl_ready | output | 1 | Controlled word taken on this edge |
| ctl_sid | input | 3 | Controlled stream number |
| ctl_data | input | 512 | Controlled data word |
| ctl_marks | input | 8 | Controlled segment markers, 2 bits per segment |
| unc_valid | input | 1 | Uncontrolled word valid |
| unc_ready | output | 1 | Uncontrolled word taken on this edge |
| unc_sid | input | 3 | Uncontrolled stream number |
| unc_data | input | 512 | Uncontrolled data word |
| unc_marks | input | 8 | Uncontrolled segment markers |
| out_valid | output | 1 | Merged word valid |
| out_ready | input | 1 | Downstream accepts merged word |
| out_sid | output | 3 | Merged stream number |
| out_data | output | 512 | Merged data word |
| out_marks | output | 8 | Merged segment markers |

## Verification
Two events can land on the same controlled word: the end of one packet and the start of the next on the same stream, while an uncontrolled packet for that stream is already waiting. The bench provokes this by keeping the uncontrolled request raised across several controlled words on its stream. One of those words closes and reopens the stream, and the bench then idles the controlled path. It judges the result by watching `unc_ready` stay low after the reopening word, and rise only after a word that closes the stream without reopening it. A second overlap is also covered: a controlled word presented in the same cycle as an uncontrolled word that continues a locked packet. Here the bench checks that only the uncontrolled word reaches the output.

// File: rtl/cup_pkg.sv
`timescale 1ns/1ps
package cup_pkg;
    localparam int MARK_W = 2;

    typedef enum logic [MARK_W-1:0] {
        MK_IDLE = 2'd0,
        MK_DATA = 2'd1,
        MK_SOP  = 2'd2,
        MK_EOP  = 2'd3
    } mark_e;
endpackage

// File: rtl/cup_seg_scan.sv
`timescale 1ns/1ps
// Walks the segment markers of one word from segment 0 upward and reports
// the packet state left behind, plus which markers were seen.
module cup_seg_scan
    import cup_pkg::*;
#(
    parameter int NSEG = 4
) (
    input  logic [NSEG*MARK_W-1:0] marks_i,
    input  logic                   open_i,
    output logic                   open_o,
    output logic                   has_sop_o,
    output logic                   has_eop_o,
    output logic                   eop_then_sop_o
);
    logic seen_eop;

    always_comb begin
        open_o         = open_i;
        has_sop_o      = 1'b0;
        has_eop_o      = 1'b0;
        eop_then_sop_o = 1'b0;
        seen_eop       = 1'b0;
        for (int k = 0; k < NSEG; k++) begin
            case (mark_e'(marks_i[k*MARK_W +: MARK_W]))
                MK_SOP: begin
                    open_o    = 1'b1;
                    has_sop_o = 1'b1;
                    if (seen_eop) eop_then_sop_o = 1'b1;
                end
                MK_EOP: begin
                    open_o    = 1'b0;
                    has_eop_o = 1'b1;
                    seen_eop  = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cup_stream_track.sv
`timescale 1ns/1ps
// One open-packet flag per stream for the controlled path.
module cup_stream_track
    import cup_pkg::*;
#(
    parameter int NSTREAM = 8,
    parameter int SID_W   = 3,
    parameter int NSEG    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd_i,
    input  logic [SID_W-1:0]       sid_i,
    input  logic [NSEG*MARK_W-1:0] marks_i,
    output logic [NSTREAM-1:0]     open_o
);
    typedef struct packed {
        logic [NSTREAM-1:0] open;
    } trk_s;

    trk_s st_d, st_q;
    logic nxt_open, cur_open;
    logic has_sop, has_eop, eop_sop;

    assign cur_open = st_q.open[sid_i];

    cup_seg_scan #(.NSEG(NSEG)) u_scan (
        .marks_i        (marks_i),
        .open_i         (cur_open),
        .open_o         (nxt_open),
        .has_sop_o      (has_sop),
        .has_eop_o      (has_eop),
        .eop_then_sop_o (eop_sop)
    );

    always_comb begin
        st_d = st_q;
        if (upd_i) st_d.open[sid_i] = nxt_open;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o = st_q.open;

    // R2: controlled stream numbers stay inside the configured range
    p_sid_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |-> (int'(sid_i) < NSTREAM));

    // R5: closing and reopening in one word leaves the stream open
    p_eop_sop_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && eop_sop) |=> st_q.open[$past(sid_i)]);
endmodule

// File: rtl/cup_grant_ctl.sv
`timescale 1ns/1ps
// Decides which source may load the output stage this cycle and holds the
// lane for an uncontrolled packet once it has begun.
module cup_grant_ctl
    import cup_pkg::*;
#(
    parameter int NSTREAM = 8,
    parameter int SID_W   = 3,
    parameter int NSEG    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv_i,
    input  logic                   ctl_valid_i,
    input  logic                   unc_valid_i,
    input  logic [SID_W-1:0]       unc_sid_i,
    input  logic [NSEG*MARK_W-1:0] unc_marks_i,
    input  logic [NSTREAM-1:0]     open_i,
    output logic                   ctl_ready_o,
    output logic                   unc_ready_o,
    output logic                   ctl_fire_o,
    output logic                   unc_fire_o
);
    typedef struct packed {
        logic lock;
    } gr_s;

    gr_s  st_d, st_q;
    logic lock_after, u_sop, u_eop, u_es;
    logic stream_busy;

    assign stream_busy = open_i[unc_sid_i];

    cup_seg_scan #(.NSEG(NSEG)) u_scan (
        .marks_i        (unc_marks_i),
        .open_i         (st_q.lock),
        .open_o         (lock_after),
        .has_sop_o      (u_sop),
        .has_eop_o      (u_eop),
        .eop_then_sop_o (u_es)
    );

    always_comb begin
        st_d        = st_q;
        ctl_ready_o = adv_i && !st_q.lock;
        unc_ready_o = adv_i && (st_q.lock ||
                      (!ctl_valid_i && unc_valid_i && !stream_busy));
        ctl_fire_o  = ctl_valid_i && ctl_ready_o;
        unc_fire_o  = unc_valid_i && unc_ready_o;
        if (unc_fire_o) st_d.lock = lock_after;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_ctl_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid_i && !st_q.lock) |-> !unc_ready_o);

    p_open_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (unc_ready_o && !st_q.lock) |-> !open_i[unc_sid_i]);

    p_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |-> !ctl_ready_o);
endmodule

// File: rtl/cup_port_arbiter.sv
`timescale 1ns/1ps
module cup_port_arbiter
    import cup_pkg::*;
#(
    parameter int SEG_W   = 128,
    parameter int NSEG    = 4,
    parameter int NSTREAM = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  ctl_valid,
    output logic                                  ctl_ready,
    input  logic [((NSTREAM>1)?$clog2(NSTREAM):1)-1:0] ctl_sid,
    input  logic [SEG_W*NSEG-1:0]                 ctl_data,
    input  logic [NSEG*2-1:0]                     ctl_marks,
    input  logic                                  unc_valid,
    output logic                                  unc_ready,
    input  logic [((NSTREAM>1)?$clog2(NSTREAM):1)-1:0] unc_sid,
    input  logic [SEG_W*NSEG-1:0]                 unc_data,
    input  logic [NSEG*2-1:0]                     unc_marks,
    output logic                                  out_valid,
    input  logic                                  out_ready,
    output logic [((NSTREAM>1)?$clog2(NSTREAM):1)-1:0] out_sid,
    output logic [SEG_W*NSEG-1:0]                 out_data,
    output logic [NSEG*2-1:0]                     out_marks
);
    localparam int SID_W  = (NSTREAM > 1) ? $clog2(NSTREAM) : 1;
    localparam int DATA_W = SEG_W * NSEG;
    localparam int MK_W   = NSEG * MARK_W;

    typedef struct packed {
        logic              valid;
        logic [SID_W-1:0]  sid;
        logic [DATA_W-1:0] data;
        logic [MK_W-1:0]   marks;
    } ost_s;

    ost_s               st_d, st_q;
    logic               adv, ctl_fire, unc_fire;
    logic [NSTREAM-1:0] open_vec;

    assign adv = !st_q.valid || out_ready;

    cup_stream_track #(.NSTREAM(NSTREAM), .SID_W(SID_W), .NSEG(NSEG)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (ctl_fire),
        .sid_i   (ctl_sid),
        .marks_i (ctl_marks),
        .open_o  (open_vec)
    );

    cup_grant_ctl #(.NSTREAM(NSTREAM), .SID_W(SID_W), .NSEG(NSEG)) u_grant (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (adv),
        .ctl_valid_i (ctl_valid),
        .unc_valid_i (unc_valid),
        .unc_sid_i   (unc_sid),
        .unc_marks_i (unc_marks),
        .open_i      (open_vec),
        .ctl_ready_o (ctl_ready),
        .unc_ready_o (unc_ready),
        .ctl_fire_o  (ctl_fire),
        .unc_fire_o  (unc_fire)
    );

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.valid = ctl_fire || unc_fire;
            if (unc_fire) begin
                st_d.sid   = unc_sid;
                st_d.data  = unc_data;
                st_d.marks = unc_marks;
            end else if (ctl_fire) begin
                st_d.sid   = ctl_sid;
                st_d.data  = ctl_data;
                st_d.marks = ctl_marks;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_sid   = st_q.sid;
    assign out_data  = st_q.data;
    assign out_marks = st_q.marks;

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_ready) |=> (out_valid && out_sid == $past(ctl_sid)
                                      && out_data == $past(ctl_data)
                                      && out_marks == $past(ctl_marks)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sid)
                                       && $stable(out_data) && $stable(out_marks)));

    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> (!ctl_ready && !unc_ready));
endmodule

// File: tb/tb_cup_port_arbiter.sv
`timescale 1ns/1ps
module tb_cup_port_arbiter;
    localparam int DATA_W = 512;

    typedef struct packed {
        logic       cv;
        logic [2:0] cs;
        logic [7:0] cm;
        logic       uv;
        logic [2:0] us;
        logic [7:0] um;
        logic       ordy;
        logic       ecr;
        logic       eur;
        logic [1:0] esrc;   // 0 none, 1 controlled, 2 uncontrolled, 3 held
        logic [3:0] req;
    } vec_t;

    function automatic vec_t mk(input logic cv, input logic [2:0] cs, input logic [7:0] cm,
                                input logic uv, input logic [2:0] us, input logic [7:0] um,
                                input logic ordy, input logic ecr, input logic eur,
                                input logic [1:0] esrc, input logic [3:0] req);
        mk = '{cv, cs, cm, uv, us, um, ordy, ecr, eur, esrc, req};
    endfunction

    // markers: 56 = SOP,D,D,D  D6 = SOP,D,D,EOP  55 = all data
    //          03 = EOP,idle..  6D = D,EOP,SOP,D (segment 0 first)
    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        mk(1,3,8'h56, 1,3,8'hD6, 1, 1,0, 1, 3),  // R3 ctl wins
        mk(0,0,8'h00, 1,3,8'hD6, 1, 1,0, 0, 4),  // R4 stream 3 open
        mk(1,3,8'h6D, 1,3,8'hD6, 1, 1,0, 1, 2),  // R2 passthrough
        mk(0,0,8'h00, 1,3,8'hD6, 1, 1,0, 0, 5),  // R5 reopened blocks
        mk(1,3,8'h03, 1,3,8'hD6, 1, 1,0, 1, 3),  // R3 closing word
        mk(0,0,8'h00, 1,3,8'hD6, 1, 1,1, 2, 4),  // R4 released after EOP
        mk(1,5,8'hD6, 0,0,8'h00, 1, 1,0, 1, 2),  // R2 short packet
        mk(0,0,8'h00, 1,5,8'hD6, 1, 1,1, 2, 6),  // R6 short leaves closed
        mk(1,1,8'h56, 0,0,8'h00, 1, 1,0, 1, 2),  // R2 open stream 1
        mk(0,0,8'h00, 1,2,8'h56, 1, 1,1, 2, 7),  // R7 other stream granted
        mk(1,1,8'h03, 1,2,8'h55, 1, 0,1, 2, 8),  // R8 lock holds lane
        mk(1,1,8'h03, 0,0,8'h00, 1, 0,1, 0, 8),  // R8 lock with unc idle
        mk(1,1,8'h03, 1,2,8'h03, 1, 0,1, 2, 8),  // R8 unc EOP releases
        mk(1,1,8'h03, 0,0,8'h00, 1, 1,0, 1, 8),  // R8 ctl resumes
        mk(1,4,8'hD6, 0,0,8'h00, 0, 0,0, 3, 9),  // R9 back-pressure
        mk(1,4,8'hD6, 0,0,8'h00, 1, 1,0, 1, 9),  // R9 released
        mk(0,0,8'h00, 0,0,8'h00, 1, 1,0, 0, 2)   // R2 idle
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_valid = 1'b0, unc_valid = 1'b0, out_ready = 1'b1;
    logic [2:0]        ctl_sid = '0, unc_sid = '0;
    logic [DATA_W-1:0] ctl_data = '0, unc_data = '0;
    logic [7:0]        ctl_marks = '0, unc_marks = '0;
    logic              ctl_ready, unc_ready, out_valid;
    logic [2:0]        out_sid;
    logic [DATA_W-1:0] out_data;
    logic [7:0]        out_marks;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cup_port_arbiter dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_sid(ctl_sid),
        .ctl_data(ctl_data), .ctl_marks(ctl_marks),
        .unc_valid(unc_valid), .unc_ready(unc_ready), .unc_sid(unc_sid),
        .unc_data(unc_data), .unc_marks(unc_marks),
        .out_valid(out_valid), .out_ready(out_ready), .out_sid(out_sid),
        .out_data(out_data), .out_marks(out_marks)
    );

    function automatic logic [DATA_W-1:0] cdat(input int i);
        cdat = {16{32'hC0DE0000 + 32'(i)}};
    endfunction
    function automatic logic [DATA_W-1:0] udat(input int i);
        udat = {16{32'hA5A50000 + 32'(i)}};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        logic [2:0]        p_sid;
        logic [DATA_W-1:0] p_data;
        logic [7:0]        p_marks;
        string             rq;
        p_sid = '0; p_data = '0; p_marks = '0;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1 chk("R1", "out_valid in reset", DATA_W'(out_valid), DATA_W'(0));
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ctl_valid = TBL[i].cv; ctl_sid = TBL[i].cs; ctl_marks = TBL[i].cm;
            ctl_data  = cdat(i);
            unc_valid = TBL[i].uv; unc_sid = TBL[i].us; unc_marks = TBL[i].um;
            unc_data  = udat(i);
            out_ready = TBL[i].ordy;
            rq = $sformatf("R%0d v%0d", TBL[i].req, i);
            #1;
            chk(rq, "ctl_ready", DATA_W'(ctl_ready), DATA_W'(TBL[i].ecr));
            chk(rq, "unc_ready", DATA_W'(unc_ready), DATA_W'(TBL[i].eur));
            @(posedge clk);
            #1;
            chk(rq, "out_valid", DATA_W'(out_valid), DATA_W'(TBL[i].esrc != 2'd0));
            case (TBL[i].esrc)
                2'd1: begin
                    chk(rq, "out_sid", DATA_W'(out_sid), DATA_W'(TBL[i].cs));
                    chk(rq, "out_marks", DATA_W'(out_marks), DATA_W'(TBL[i].cm));
                    chk(rq, "out_data", out_data, cdat(i));
                end
                2'd2: begin
                    chk(rq, "out_sid", DATA_W'(out_sid), DATA_W'(TBL[i].us));
                    chk(rq, "out_marks", DATA_W'(out_marks), DATA_W'(TBL[i].um));
                    chk(rq, "out_data", out_data, udat(i));
                end
                2'd3: begin
                    chk(rq, "out_sid held", DATA_W'(out_sid), DATA_W'(p_sid));
                    chk(rq, "out_marks held", DATA_W'(out_marks), DATA_W'(p_marks));
                    chk(rq, "out_data held", out_data, p_data);
                end
                default: ;
            endcase
            p_sid = out_sid; p_data = out_data; p_marks = out_marks;
        end

        // R1: reset in the middle of a controlled packet clears stream state
        @(negedge clk);
        ctl_valid = 1'b1; ctl_sid = 3'd6; ctl_marks = 8'h56; ctl_data = cdat(40);
        unc_valid = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        ctl_valid = 1'b0;
        unc_valid = 1'b1; unc_sid = 3'd6; unc_marks = 8'hD6; unc_data = udat(41);
        #1 chk("R4 pre-reset", "unc_ready", DATA_W'(unc_ready), DATA_W'(0));
        rst_n = 1'b0; unc_valid = 1'b0;
        @(posedge clk);
        #1 chk("R1 mid reset", "out_valid", DATA_W'(out_valid), DATA_W'(0));
        @(negedge clk);
        rst_n = 1'b1;
        unc_valid = 1'b1;
        #1 chk("R1 post-reset", "unc_ready", DATA_W'(unc_ready), DATA_W'(1));
        @(posedge clk);
        #1 chk("R1 post-reset", "out_data", out_data, udat(41));
        @(negedge clk);
        unc_valid = 1'b0;

        // R5: close then reopen stream 0 in one word, then a plain close
        @(negedge clk);
        ctl_valid = 1'b1; ctl_sid = 3'd0; ctl_marks = 8'hD6;
        @(negedge clk);
        ctl_marks = 8'h6D;
        @(negedge clk);
        ctl_valid = 1'b0;
        unc_valid = 1'b1; unc_sid = 3'd0; unc_marks = 8'hD6; unc_data = udat(50);
        #1 chk("R5 reopen", "unc_ready", DATA_W'(unc_ready), DATA_W'(0));
        @(negedge clk);
        ctl_valid = 1'b1; ctl_marks = 8'h03;
        #1 chk("R3 closing", "unc_ready", DATA_W'(unc_ready), DATA_W'(0));
        @(negedge clk);
        ctl_valid = 1'b0;
        #1 chk("R5 after close", "unc_ready", DATA_W'(unc_ready), DATA_W'(1));
        @(posedge clk);
        #1 chk("R5 after close", "out_data", out_data, udat(50));
        @(negedge clk);
        unc_valid = 1'b0;
        repeat (2) @(negedge clk);

        finished = 1'b1;
        summary();
    end
endmodule